// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO Controller

This block is a single-clock FIFO with two flag conventions, chosen once at master reset. In standard mode the write-side flag is an active-low "full" indication and the read-side flag is an active-low "empty" indication. A read is an explicit request, and the requested word shows up on the data output after the read edge.

In first-word-fall-through (FWFT) mode the same two pins swap meaning and polarity. The write-side pin becomes an active-low "input ready" and the read-side pin becomes an active-low "output ready". The oldest word is pushed into the output register without being asked for. A read acknowledges and consumes the word on display. Because the output register holds a word of its own, the FIFO takes one more word than the memory depth before it refuses writes.

A partial reset empties the FIFO and restores the flags but keeps the mode that master reset selected. Enables are active low.

Top module: `dualmode_fifo`

## Requirements
- R1: On a clock edge with `rst_n` LOW the mode is taken from `fwft_sel` (0 = standard, 1 = FWFT), the FIFO empties and `rdata` becomes 0. After reset, standard mode shows `wr_flag`=1 and `rd_flag`=0, and FWFT mode shows `wr_flag`=0 and `rd_flag`=1.
- R2: In standard mode, with no reads, `wr_flag` goes LOW on the edge of the DEPTH-th write. Writes made while it is LOW are not stored.
- R3: In standard mode `rd_flag` is LOW exactly when no word is stored. A read while it is LOW leaves `rdata` and the flags unchanged.
- R4: In standard mode, a read (`ren_n` LOW) while `rd_flag` is HIGH places the oldest stored word on `rdata` on that edge. Words come out in write order.
- R5: In FWFT mode `wr_flag` stays LOW while space remains and goes HIGH on the edge of the (DEPTH+1)-th write when there are no reads. Writes made while it is HIGH are not stored.
- R6: In FWFT mode, a word written into an empty FIFO appears on `rdata` with no read. It appears on the second edge after the write edge, and `rd_flag` goes LOW on that same edge.
- R7: In FWFT mode, a read while `rd_flag` is LOW consumes the displayed word. The next stored word appears on the same edge. If no word is stored, `rd_flag` goes HIGH and `rdata` keeps the last word.
- R8: In FWFT mode, reads while `rd_flag` is HIGH are ignored and `rdata` is unchanged.
- R9: On an edge with `prst_n` LOW, the FIFO empties, `rdata` becomes 0 and the flags return to the reset state of the current mode. `fwft_sel` is ignored.
- R10: A read and a write in the same cycle each take effect when their own flag permits. At full, the write is refused and the read proceeds. When the FIFO is empty in standard mode, the read is refused and the write proceeds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by write and read sides |
| rst_n | input | 1 | Master reset, active low, synchronous; samples `fwft_sel` |
| prst_n | input | 1 | Partial reset, active low, synchronous; keeps the mode |
| fwft_sel | input | 1 | Mode chosen at master reset: 0 standard, 1 FWFT |
| wen_n | input | 1 | Write enable, active low |
| wdata | input | DATA_W | Write data |
| ren_n | input | 1 | Read enable, active low |
| rdata | output | DATA_W | Output data register |
| wr_flag | output | 1 | Standard: full, active low. FWFT: input ready, active low |
| rd_flag | output | 1 | Standard: empty, active low. FWFT: output ready, active low |

## Verification
Writes and reads can land in the same cycle, and the hard cases are at the ends of the fill range. In standard mode, a bench sweep refills the FIFO to every level from empty to full and then issues a combined write and read at that level. A bench model of the stored words decides which of the two operations each flag permits. The resulting `rdata`, both flags and the drained word sequence are compared against that model. In FWFT mode, the bench provokes the same collision in two places. One is where the last displayed word is consumed while a new word arrives, so the prefetch must follow one edge later. The other is at full, where the refused write must not appear in the drained order.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

   typedef enum logic {
      MODE_STD  = 1'b0,
      MODE_FWFT = 1'b1
   } fifo_mode_e;

endpackage

// File: rtl/dmf_ptr.sv
module dmf_ptr #(
   parameter int DEPTH = 8,
   parameter int AW    = 3,
   parameter int CW    = 4
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   output logic [AW-1:0] wptr,
   output logic [AW-1:0] rptr,
   output logic [CW-1:0] count
);

   logic [AW-1:0] wnext;
   logic [AW-1:0] rnext;

   generate
      if (DEPTH == (1 << AW)) begin : g_pow2
         assign wnext = wptr + 1'b1;
         assign rnext = rptr + 1'b1;
      end else begin : g_wrap
         assign wnext = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rnext = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (clr) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push) wptr <= wnext;
         if (pop)  rptr <= rnext;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R2: the stored count never passes the memory depth
   a_r2_no_overflow: assert property (@(posedge clk) disable iff (clr)
      count <= CW'(DEPTH));

   // R2: a push into a full memory only happens alongside a pop
   a_r2_full_push_needs_pop: assert property (@(posedge clk) disable iff (clr)
      (count == CW'(DEPTH) && push) |-> pop);

   // R3: no pop from an empty memory
   a_r3_no_underflow: assert property (@(posedge clk) disable iff (clr)
      (count == '0) |-> !pop);

endmodule

// File: rtl/dmf_store.sv
module dmf_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   parameter int AW     = 3
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rword
);

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rword = cells[raddr];

endmodule

// File: rtl/dmf_outreg.sv
module dmf_outreg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              track,
   input  logic              load,
   input  logic              drop,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              valid
);

   always_ff @(posedge clk) begin
      if (clr) begin
         dout  <= '0;
         valid <= 1'b0;
      end else if (load) begin
         dout  <= din;
         valid <= track;
      end else if (drop) begin
         valid <= 1'b0;
      end
   end

   // R7: consuming the last word keeps the data and clears the valid bit
   a_r7_drop_keeps_data: assert property (@(posedge clk) disable iff (clr)
      (drop && !load) |=> ($stable(dout) && !valid));

endmodule

// File: rtl/dmf_ctrl.sv
module dmf_ctrl
   import dmf_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int CW    = 4
) (
   input  fifo_mode_e    mode,
   input  logic          wen_n,
   input  logic          ren_n,
   input  logic [CW-1:0] count,
   input  logic          valid,
   output logic          push,
   output logic          pop,
   output logic          drop,
   output logic          wr_flag,
   output logic          rd_flag
);

   logic mem_empty;
   logic mem_full;
   logic take;

   assign mem_empty = (count == '0);
   assign mem_full  = (count == CW'(DEPTH));

   always_comb begin
      push    = 1'b0;
      pop     = 1'b0;
      drop    = 1'b0;
      take    = 1'b0;
      wr_flag = 1'b1;
      rd_flag = 1'b0;
      unique case (mode)
         MODE_STD: begin
            wr_flag = !mem_full;
            rd_flag = !mem_empty;
            push    = !wen_n && !mem_full;
            pop     = !ren_n && !mem_empty;
         end
         MODE_FWFT: begin
            wr_flag = mem_full && valid;
            rd_flag = !valid;
            take    = !ren_n && valid;
            pop     = !mem_empty && (!valid || take);
            drop    = take && mem_empty;
            push    = !wen_n && !(mem_full && valid);
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/dualmode_fifo.sv
module dualmode_fifo
   import dmf_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prst_n,
   input  logic              fwft_sel,
   input  logic              wen_n,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ren_n,
   output logic [DATA_W-1:0] rdata,
   output logic              wr_flag,
   output logic              rd_flag
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("dualmode_fifo: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("dualmode_fifo: DATA_W must be at least 1");
      end
   endgenerate

   fifo_mode_e        mode_q;
   logic              clr;
   logic              push;
   logic              pop;
   logic              drop;
   logic              valid;
   logic [AW-1:0]     wptr;
   logic [AW-1:0]     rptr;
   logic [CW-1:0]     count;
   logic [DATA_W-1:0] rword;

   assign clr = !rst_n || !prst_n;

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= fifo_mode_e'(fwft_sel);
   end

   dmf_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
      .mode    (mode_q),
      .wen_n   (wen_n),
      .ren_n   (ren_n),
      .count   (count),
      .valid   (valid),
      .push    (push),
      .pop     (pop),
      .drop    (drop),
      .wr_flag (wr_flag),
      .rd_flag (rd_flag)
   );

   dmf_ptr #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptr (
      .clk   (clk),
      .clr   (clr),
      .push  (push),
      .pop   (pop),
      .wptr  (wptr),
      .rptr  (rptr),
      .count (count)
   );

   dmf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
      .clk   (clk),
      .we    (push),
      .waddr (wptr),
      .wdata (wdata),
      .raddr (rptr),
      .rword (rword)
   );

   dmf_outreg #(.DATA_W(DATA_W)) u_out (
      .clk   (clk),
      .clr   (clr),
      .track (mode_q == MODE_FWFT),
      .load  (pop),
      .drop  (drop),
      .din   (rword),
      .dout  (rdata),
      .valid (valid)
   );

   // R3: standard mode, empty flag LOW -> output data does not move
   a_r3_empty_read_ignored: assert property (@(posedge clk) disable iff (clr)
      (mode_q == MODE_STD && !rd_flag) |=> $stable(rdata));

   // R8: FWFT, nothing displayed and nothing stored -> data holds and flag stays HIGH
   a_r8_idle_output_holds: assert property (@(posedge clk) disable iff (clr)
      (mode_q == MODE_FWFT && rd_flag && count == '0) |=> ($stable(rdata) && rd_flag));

   // R6: FWFT, a stored word with nothing displayed is shown on the next edge
   a_r6_prefetch: assert property (@(posedge clk) disable iff (clr)
      (mode_q == MODE_FWFT && rd_flag && count != '0) |=> !rd_flag);

   // R7: FWFT, consuming the last word raises output-ready and keeps the data
   a_r7_last_read: assert property (@(posedge clk) disable iff (clr)
      (mode_q == MODE_FWFT && !rd_flag && !ren_n && count == '0) |=> (rd_flag && $stable(rdata)));

   // R9: the mode only changes under master reset
   a_r9_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> $stable(mode_q));

endmodule

// File: tb/sim_dualmode_fifo.sv
module sim_dualmode_fifo;

   localparam int D = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       prst_n = 1'b1;
   logic       fwft_sel = 1'b0;
   logic       wen_n = 1'b1;
   logic [7:0] wdata = '0;
   logic       ren_n = 1'b1;
   logic [7:0] rdata;
   logic       wr_flag;
   logic       rd_flag;

   int checks = 0;
   int errors = 0;

   always #10 clk = !clk;

   dualmode_fifo #(.DATA_W(8), .DEPTH(D)) u0 (
      .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .fwft_sel(fwft_sel),
      .wen_n(wen_n), .wdata(wdata), .ren_n(ren_n),
      .rdata(rdata), .wr_flag(wr_flag), .rd_flag(rd_flag)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input logic w, input logic [7:0] d, input logic r);
      wen_n = !w;
      wdata = d;
      ren_n = !r;
      @(negedge clk);
      wen_n = 1'b1;
      ren_n = 1'b1;
   endtask

   task automatic master(input logic m);
      rst_n = 1'b0;
      fwft_sel = m;
      step(0, 0, 0);
      step(0, 0, 0);
      rst_n = 1'b1;
      fwft_sel = !m;
   endtask

   task automatic partial();
      prst_n = 1'b0;
      step(0, 0, 0);
      prst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] q[$];
      logic [7:0] exp_rd;
      logic       rd_ok;
      logic       wr_ok;
      @(negedge clk);

      // ---------------- standard mode ----------------
      master(1'b0);
      chk("R1 std wr_flag", wr_flag, 1);
      chk("R1 std rd_flag", rd_flag, 0);
      chk("R1 std rdata", rdata, 0);
      step(0, 0, 1);
      chk("R3 read on empty rd_flag", rd_flag, 0);
      chk("R3 read on empty rdata", rdata, 0);

      for (int i = 0; i < D; i++) begin
         step(1, 8'(8'h30 + i), 0);
         chk("R2 wr_flag during fill", wr_flag, (i == D - 1) ? 0 : 1);
         chk("R3 rd_flag during fill", rd_flag, 1);
      end
      step(1, 8'hEE, 0);
      chk("R2 write while full keeps flag", wr_flag, 0);
      for (int i = 0; i < D; i++) begin
         step(0, 0, 1);
         chk("R4 read order", rdata, 8'(8'h30 + i));
         chk("R3 rd_flag during drain", rd_flag, (i == D - 1) ? 0 : 1);
         chk("R2 wr_flag during drain", wr_flag, 1);
      end
      step(0, 0, 1);
      chk("R3 read on empty keeps data", rdata, 8'(8'h30 + D - 1));
      chk("R3 read on empty keeps flag", rd_flag, 0);

      // R10 / R9: sweep every fill level, collide a write and a read
      for (int k = 0; k <= D; k++) begin
         partial();
         chk("R9 std partial wr_flag", wr_flag, 1);
         chk("R9 std partial rd_flag", rd_flag, 0);
         chk("R9 std partial rdata", rdata, 0);
         q.delete();
         exp_rd = 8'h00;
         for (int i = 0; i < k; i++) begin
            step(1, 8'(k * 16 + i), 0);
            q.push_back(8'(k * 16 + i));
         end
         rd_ok = (q.size() != 0);
         wr_ok = (q.size() != D);
         step(1, 8'(8'hA0 + k), 1);
         if (rd_ok) exp_rd = q.pop_front();
         if (wr_ok) q.push_back(8'(8'hA0 + k));
         chk("R10 collide rdata", rdata, exp_rd);
         chk("R10 collide wr_flag", wr_flag, (q.size() != D) ? 1 : 0);
         chk("R10 collide rd_flag", rd_flag, (q.size() != 0) ? 1 : 0);
         while (q.size() != 0) begin
            exp_rd = q.pop_front();
            step(0, 0, 1);
            chk("R10 drain after collide", rdata, exp_rd);
         end
         chk("R3 empty after drain", rd_flag, 0);
      end

      // ---------------- FWFT mode ----------------
      master(1'b1);
      chk("R1 fwft wr_flag", wr_flag, 0);
      chk("R1 fwft rd_flag", rd_flag, 1);
      chk("R1 fwft rdata", rdata, 0);
      step(0, 0, 1);
      chk("R8 read with nothing shown flag", rd_flag, 1);
      chk("R8 read with nothing shown data", rdata, 0);

      step(1, 8'h5A, 0);
      chk("R6 not shown on write edge", rd_flag, 1);
      step(0, 0, 0);
      chk("R6 shown second edge flag", rd_flag, 0);
      chk("R6 shown second edge data", rdata, 8'h5A);
      step(0, 0, 1);
      chk("R7 last read flag", rd_flag, 1);
      chk("R7 last read keeps data", rdata, 8'h5A);
      step(0, 0, 1);
      chk("R8 extra read keeps data", rdata, 8'h5A);

      partial();
      for (int j = 1; j <= D + 1; j++) begin
         step(1, 8'(8'h60 + j), 0);
         chk("R5 wr_flag during fill", wr_flag, (j == D + 1) ? 1 : 0);
         chk("R6 rd_flag during fill", rd_flag, (j == 1) ? 1 : 0);
      end
      chk("R6 head word shown", rdata, 8'h61);
      step(1, 8'hEE, 0);
      chk("R5 write while full keeps flag", wr_flag, 1);
      for (int j = 2; j <= D + 1; j++) begin
         step(0, 0, 1);
         chk("R7 next word shown", rdata, 8'(8'h60 + j));
         chk("R7 rd_flag stays LOW", rd_flag, 0);
         chk("R5 space after read", wr_flag, 0);
      end
      step(0, 0, 1);
      chk("R7 drained flag", rd_flag, 1);
      chk("R7 drained keeps data", rdata, 8'(8'h60 + D + 1));

      // R10: consume last shown word while a new word arrives
      step(1, 8'h71, 0);
      step(0, 0, 0);
      step(1, 8'h72, 1);
      chk("R10 fwft collide flag", rd_flag, 1);
      chk("R10 fwft collide data", rdata, 8'h71);
      step(0, 0, 0);
      chk("R10 fwft new word flag", rd_flag, 0);
      chk("R10 fwft new word data", rdata, 8'h72);

      // R10: full FWFT, write refused, read proceeds
      partial();
      for (int j = 0; j <= D; j++) step(1, 8'(8'h80 + j), 0);
      chk("R5 full again", wr_flag, 1);
      step(1, 8'hEE, 1);
      chk("R10 fwft full collide data", rdata, 8'h81);
      chk("R10 fwft full collide wr_flag", wr_flag, 0);
      for (int j = 2; j <= D; j++) begin
         step(0, 0, 1);
         chk("R10 fwft drain order", rdata, 8'(8'h80 + j));
      end
      step(0, 0, 1);
      chk("R10 refused write absent", rd_flag, 1);

      // R9: partial reset keeps FWFT although fwft_sel is now 0
      step(1, 8'h90, 0);
      fwft_sel = 1'b0;
      partial();
      chk("R9 fwft partial wr_flag", wr_flag, 0);
      chk("R9 fwft partial rd_flag", rd_flag, 1);
      chk("R9 fwft partial rdata", rdata, 0);
      step(1, 8'h91, 0);
      step(0, 0, 0);
      chk("R9 still fwft after partial", rd_flag, 0);
      chk("R9 still fwft data", rdata, 8'h91);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule